// File: doc/BRIEF.md
# Pipeline Hazard and Operand-Forwarding Controller

This block is the combinational control unit of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the register indices and valid bits held in the decode and execute stages and at the destination, write-enable, load and valid information of the execute, memory and writeback stages. From these it picks the source of each execute-stage operand and decides whether the front of the pipe must hold. It also turns a resolved taken branch into squash requests for the younger stages.

Every bypass path ends at the execute-stage operand inputs. A value needed later, such as store data, is still picked up there. The one case a bypass cannot cover is a load sitting in execute whose result a decode-stage instruction needs. In that case decode and fetch hold for one cycle and an invalid no-op enters execute. Branches are predicted not taken and resolve at the end of the memory stage. A taken branch clears the valid bits of the fetch, decode and execute stages in the same cycle it redirects the fetch address, and that squash wins over any stall raised in the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: Operand select encoding is 0 = register-file value, 1 = bypass from the memory-stage producer, 2 = bypass from the writeback-stage producer. When the execute stage is valid and an execute source index equals the destination of a valid, writing memory-stage instruction whose destination is not 0, that operand's select is 1.
- R2: If no memory-stage match exists and the source equals the destination of a valid, writing writeback-stage instruction whose destination is not 0, the select is 2.
- R3: When both producers match the same source, the memory-stage (younger) producer wins and the select is 1.
- R4: A destination of register 0 never causes a bypass and never causes a stall.
- R5: A producer that is not valid, or whose write enable is low, never causes a bypass. When the execute stage is invalid, both selects are 0.
- R6: A load-use stall asserts stall_if, stall_id and bubble_ex together. It requires a valid load in execute with write enable high and a nonzero destination, plus a valid decode instruction whose used source (rs1 or rs2) matches that destination.
- R7: The stall is raised only in the R6 case. There is no stall when the matching source is unused, the decode stage is invalid, the execute instruction is not a load, or no index matches.
- R8: A taken branch asserts squash_if, squash_id and squash_ex together in the same cycle. All three are low otherwise.
- R9: When a branch is taken in the same cycle as a load-use hazard, the squash wins and stall_if, stall_id and bubble_ex are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode-stage instruction is valid |
| id_rs1 | input | REG_W | Decode first source index |
| id_rs2 | input | REG_W | Decode second source index |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_valid | input | 1 | Execute-stage instruction is valid |
| ex_rs1 | input | REG_W | Execute first source index |
| ex_rs2 | input | REG_W | Execute second source index |
| ex_rd | input | REG_W | Execute destination index |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory-stage instruction is valid |
| mem_rd | input | REG_W | Memory-stage destination index |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_valid | input | 1 | Writeback-stage instruction is valid |
| wb_rd | input | REG_W | Writeback destination index |
| wb_wr_en | input | 1 | Writeback instruction writes a register |
| br_taken | input | 1 | Branch in the memory stage resolved taken |
| fwd_sel_a | output | 2 | Select for execute first operand |
| fwd_sel_b | output | 2 | Select for execute second operand |
| stall_if | output | 1 | Hold the fetch stage |
| stall_id | output | 1 | Hold the decode stage |
| bubble_ex | output | 1 | Load an invalid no-op into execute |
| squash_if | output | 1 | Invalidate the fetch-stage instruction |
| squash_id | output | 1 | Invalidate the decode-stage instruction |
| squash_ex | output | 1 | Invalidate the execute-stage instruction |

## Verification
A taken branch and a load-use hazard can both occur in the same cycle, because the load in execute is younger than the branch in memory. The bench sets up a matching load-use pair and raises br_taken on the same input vector. It expects all three squash outputs high and all stall and bubble outputs low. It then drops br_taken and expects the stall to return, which shows that only the squash suppressed it.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_REGFILE  = 2'd0,
    FWD_FROM_MEM = 2'd1,
    FWD_FROM_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             use_valid,
  input  logic [REG_W-1:0] src_idx,
  input  logic             mem_valid,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr_en,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wr_en,
  output fwd_sel_e         sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_valid && mem_wr_en && (mem_rd != '0) && (mem_rd == src_idx);
    wb_hit  = wb_valid  && wb_wr_en  && (wb_rd  != '0) && (wb_rd  == src_idx);
    sel = FWD_REGFILE;
    if (use_valid) begin
      if (mem_hit)     sel = FWD_FROM_MEM;
      else if (wb_hit) sel = FWD_FROM_WB;
    end
  end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                       id_valid,
  input  logic [NSRC-1:0][REG_W-1:0] id_src,
  input  logic [NSRC-1:0]            id_used,
  input  logic                       ex_valid,
  input  logic [REG_W-1:0]           ex_rd,
  input  logic                       ex_wr_en,
  input  logic                       ex_is_load,
  output logic                       hazard
);
  logic            ld_live;
  logic [NSRC-1:0] src_hit;

  assign ld_live = ex_valid && ex_is_load && ex_wr_en && (ex_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = id_used[g] && (id_src[g] == ex_rd);
  end

  assign hazard = ld_live && id_valid && (|src_hit);
endmodule

// File: rtl/hz_flow_ctrl.sv
module hz_flow_ctrl (
  input  logic hazard,
  input  logic br_taken,
  output logic stall_if,
  output logic stall_id,
  output logic bubble_ex,
  output logic squash_if,
  output logic squash_id,
  output logic squash_ex
);
  logic hold;

  always_comb begin
    hold      = hazard && !br_taken;
    stall_if  = hold;
    stall_id  = hold;
    bubble_ex = hold;
    squash_if = br_taken;
    squash_id = br_taken;
    squash_ex = br_taken;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_rs1_used,
  input  logic             id_rs2_used,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic             mem_valid,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr_en,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wr_en,
  input  logic             br_taken,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             stall_if,
  output logic             stall_id,
  output logic             bubble_ex,
  output logic             squash_if,
  output logic             squash_id,
  output logic             squash_ex
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] ex_src, id_src;
  logic [NSRC-1:0]            id_used;
  fwd_sel_e                   sel [NSRC];
  logic                       ld_hazard;

  assign ex_src  = {ex_rs2, ex_rs1};
  assign id_src  = {id_rs2, id_rs1};
  assign id_used = {id_rs2_used, id_rs1_used};

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    hz_fwd_unit #(.REG_W(REG_W)) u_fwd (
      .use_valid (ex_valid),
      .src_idx   (ex_src[g]),
      .mem_valid (mem_valid),
      .mem_rd    (mem_rd),
      .mem_wr_en (mem_wr_en),
      .wb_valid  (wb_valid),
      .wb_rd     (wb_rd),
      .wb_wr_en  (wb_wr_en),
      .sel       (sel[g])
    );
  end

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];

  hz_loaduse_det #(.REG_W(REG_W), .NSRC(NSRC)) u_ld (
    .id_valid   (id_valid),
    .id_src     (id_src),
    .id_used    (id_used),
    .ex_valid   (ex_valid),
    .ex_rd      (ex_rd),
    .ex_wr_en   (ex_wr_en),
    .ex_is_load (ex_is_load),
    .hazard     (ld_hazard)
  );

  hz_flow_ctrl u_flow (
    .hazard    (ld_hazard),
    .br_taken  (br_taken),
    .stall_if  (stall_if),
    .stall_id  (stall_id),
    .bubble_ex (bubble_ex),
    .squash_if (squash_if),
    .squash_id (squash_id),
    .squash_ex (squash_ex)
  );
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             ex_valid,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rs2,
  input logic             ex_is_load,
  input logic             br_taken,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b,
  input logic             stall_if,
  input logic             stall_id,
  input logic             bubble_ex,
  input logic             squash_if,
  input logic             squash_id,
  input logic             squash_ex
);
  always_comb begin
    AST_SEL_ENCODING: assert (fwd_sel_a != 2'd3 && fwd_sel_b != 2'd3) else $error("bad select code"); // R1
    AST_X0_NO_BYPASS: assert ((ex_rs1 != '0 || fwd_sel_a == 2'd0) && (ex_rs2 != '0 || fwd_sel_b == 2'd0)) else $error("x0 bypassed"); // R4
    AST_IDLE_EX_NO_BYPASS: assert (ex_valid || (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0)) else $error("bypass with idle EX"); // R5
    AST_STALL_TOGETHER: assert (stall_if == stall_id && stall_id == bubble_ex) else $error("stall outputs split"); // R6
    AST_STALL_NEEDS_LOAD: assert (!stall_id || (ex_valid && ex_is_load)) else $error("stall without load"); // R7
    AST_SQUASH_TOGETHER: assert (squash_if == br_taken && squash_id == br_taken && squash_ex == br_taken) else $error("squash mismatch"); // R8
    AST_SQUASH_OVER_STALL: assert (!(br_taken && (stall_if || bubble_ex))) else $error("stall during squash"); // R9
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .ex_valid   (ex_valid),
  .ex_rs1     (ex_rs1),
  .ex_rs2     (ex_rs2),
  .ex_is_load (ex_is_load),
  .br_taken   (br_taken),
  .fwd_sel_a  (fwd_sel_a),
  .fwd_sel_b  (fwd_sel_b),
  .stall_if   (stall_if),
  .stall_id   (stall_id),
  .bubble_ex  (bubble_ex),
  .squash_if  (squash_if),
  .squash_id  (squash_id),
  .squash_ex  (squash_ex)
);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic id_valid, id_rs1_used, id_rs2_used;
  logic [REG_W-1:0] id_rs1, id_rs2;
  logic ex_valid, ex_wr_en, ex_is_load;
  logic [REG_W-1:0] ex_rs1, ex_rs2, ex_rd;
  logic mem_valid, mem_wr_en, wb_valid, wb_wr_en, br_taken;
  logic [REG_W-1:0] mem_rd, wb_rd;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic stall_if, stall_id, bubble_ex, squash_if, squash_id, squash_ex;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  hazard_ctrl #(.REG_W(REG_W)) i_hazard_ctrl (
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .ex_valid(ex_valid), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .br_taken(br_taken),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .stall_if(stall_if), .stall_id(stall_id), .bubble_ex(bubble_ex),
    .squash_if(squash_if), .squash_id(squash_id), .squash_ex(squash_ex)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_rs1_used = 0; id_rs2_used = 0;
    ex_valid = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wr_en = 0; ex_is_load = 0;
    mem_valid = 0; mem_rd = 0; mem_wr_en = 0;
    wb_valid = 0; wb_rd = 0; wb_wr_en = 0; br_taken = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic int stall3();
    return {29'd0, stall_if, stall_id, bubble_ex};
  endfunction

  function automatic int squash3();
    return {29'd0, squash_if, squash_id, squash_ex};
  endfunction

  task automatic t_reset_state();
    settle();
    chk("R5 idle sel_a", fwd_sel_a, 0);
    chk("R5 idle sel_b", fwd_sel_b, 0);
    chk("R7 idle stall", stall3(), 0);
    chk("R8 idle squash", squash3(), 0);
  endtask

  task automatic t_r1_mem_bypass();
    @(posedge clk); idle();
    ex_valid = 1; ex_rs1 = 5'd7; ex_rs2 = 5'd9;
    mem_valid = 1; mem_wr_en = 1; mem_rd = 5'd7;
    settle();
    chk("R1 sel_a from mem", fwd_sel_a, 1);
    chk("R1 sel_b untouched", fwd_sel_b, 0);
    mem_rd = 5'd9; settle();
    chk("R1 sel_b from mem", fwd_sel_b, 1);
    chk("R1 sel_a back to rf", fwd_sel_a, 0);
  endtask

  task automatic t_r2_wb_bypass();
    @(posedge clk); idle();
    ex_valid = 1; ex_rs1 = 5'd3; ex_rs2 = 5'd3;
    wb_valid = 1; wb_wr_en = 1; wb_rd = 5'd3;
    settle();
    chk("R2 sel_a from wb", fwd_sel_a, 2);
    chk("R2 sel_b from wb", fwd_sel_b, 2);
  endtask

  task automatic t_r3_priority();
    @(posedge clk); idle();
    ex_valid = 1; ex_rs1 = 5'd12; ex_rs2 = 5'd20;
    mem_valid = 1; mem_wr_en = 1; mem_rd = 5'd12;
    wb_valid = 1; wb_wr_en = 1; wb_rd = 5'd12;
    settle();
    chk("R3 younger wins", fwd_sel_a, 1);
    wb_rd = 5'd20; settle();
    chk("R3 split sources a", fwd_sel_a, 1);
    chk("R3 split sources b", fwd_sel_b, 2);
  endtask

  task automatic t_r4_x0();
    @(posedge clk); idle();
    ex_valid = 1; ex_rs1 = 0; ex_rs2 = 0;
    mem_valid = 1; mem_wr_en = 1; mem_rd = 0;
    wb_valid = 1; wb_wr_en = 1; wb_rd = 0;
    settle();
    chk("R4 x0 no bypass a", fwd_sel_a, 0);
    chk("R4 x0 no bypass b", fwd_sel_b, 0);
    id_valid = 1; id_rs1_used = 1; id_rs1 = 0;
    ex_is_load = 1; ex_wr_en = 1; ex_rd = 0;
    settle();
    chk("R4 x0 load no stall", stall3(), 0);
  endtask

  task automatic t_r5_dead_producer();
    @(posedge clk); idle();
    ex_valid = 1; ex_rs1 = 5'd4; ex_rs2 = 5'd4;
    mem_valid = 0; mem_wr_en = 1; mem_rd = 5'd4;
    wb_valid = 1; wb_wr_en = 0; wb_rd = 5'd4;
    settle();
    chk("R5 invalid mem/nowrite wb", fwd_sel_a, 0);
    mem_valid = 1; mem_wr_en = 0; wb_wr_en = 1; wb_valid = 0;
    settle();
    chk("R5 nowrite mem/invalid wb", fwd_sel_b, 0);
    mem_wr_en = 1; ex_valid = 0;
    settle();
    chk("R5 invalid EX no bypass", fwd_sel_a, 0);
  endtask

  task automatic t_r6_load_use();
    @(posedge clk); idle();
    id_valid = 1; id_rs1 = 5'd8; id_rs1_used = 1; id_rs2 = 5'd1; id_rs2_used = 1;
    ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 5'd8;
    settle();
    chk("R6 stall on rs1", stall3(), 7);
    ex_rd = 5'd1; settle();
    chk("R6 stall on rs2", stall3(), 7);
    chk("R6 no squash", squash3(), 0);
  endtask

  task automatic t_r7_no_false_stall();
    @(posedge clk); idle();
    id_valid = 1; id_rs1 = 5'd8; id_rs1_used = 0; id_rs2 = 5'd2; id_rs2_used = 1;
    ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 5'd8;
    settle();
    chk("R7 unused source", stall3(), 0);
    id_rs1_used = 1; id_valid = 0; settle();
    chk("R7 invalid ID", stall3(), 0);
    id_valid = 1; ex_is_load = 0; settle();
    chk("R7 non-load producer", stall3(), 0);
    ex_is_load = 1; ex_rd = 5'd9; settle();
    chk("R7 no index match", stall3(), 0);
  endtask

  task automatic t_r8_branch();
    @(posedge clk); idle();
    br_taken = 1; settle();
    chk("R8 squash on taken", squash3(), 7);
    br_taken = 0; settle();
    chk("R8 squash clear", squash3(), 0);
  endtask

  task automatic t_r9_squash_wins();
    @(posedge clk); idle();
    id_valid = 1; id_rs1 = 5'd6; id_rs1_used = 1;
    ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 5'd6;
    br_taken = 1; settle();
    chk("R9 squash asserted", squash3(), 7);
    chk("R9 stall suppressed", stall3(), 0);
    br_taken = 0; settle();
    chk("R9 stall returns", stall3(), 7);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_r1_mem_bypass();
    t_r2_wb_bypass();
    t_r3_priority();
    t_r4_x0();
    t_r5_dead_producer();
    t_r6_load_use();
    t_r7_no_false_stall();
    t_r8_branch();
    t_r9_squash_wins();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule